// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

A clocked controller that sits between a synchronous request port and an external asynchronous static RAM. The RAM holds 16,384 one-bit words. It has a 14-bit address, a separate one-bit data input and a separate one-bit data output, and two active-low strobes: a chip select and a write enable. There is no output-enable pin, so the two strobes alone choose between standby, read and write. Each request is a single-cycle valid/ready transaction. The controller expands it into a strobe sequence whose phases last a whole number of clock cycles. Each count is the ceiling of a nanosecond (picosecond) timing value divided by the clock period, all given as parameters.

When no access is in progress, the chip select is held inactive so that the memory stays in standby. A read holds the address and chip select for the access time, samples the data output at the end of that window and returns the bit with a one-cycle valid pulse. A write drives address and data one cycle ahead of the write strobe and holds the strobe for the longer of the pulse-width and data-setup counts. It then gives one recovery cycle, with the strobe released and the address still held, before the address may change.

A retention handshake lets the system lower the memory supply. A request to retain is honoured only once the controller is idle. The controller then acknowledges with both strobes inactive. After the request is withdrawn, the controller waits out a recovery window before it accepts new accesses. Requests that arrive during retention or recovery wait and are not lost.

Top module: `sram_seq_ctrl`

## Requirements
- R1: Out of reset, and whenever no access is in progress, mem_cs_no and mem_we_no are 1, rd_valid_o is 0, and req_ready_o is 1 unless retention blocks it.
- R2: A read holds mem_cs_no at 0, mem_we_no at 1 and mem_addr_o at the request address for exactly ACC = ceil(T_AA_PS / CLK_PERIOD_PS) cycles, starting in the cycle after acceptance.
- R3: The read bit is sampled from mem_dout_i at the end of the last access cycle. It appears on rd_data_o with rd_valid_o high for exactly one cycle, in cycle ACC+1 after acceptance.
- R4: In the first cycle after a write is accepted, mem_addr_o and mem_din_o carry the request, mem_cs_no is 0 and mem_we_no is still 1.
- R5: mem_we_no is then 0 for exactly PULSE = max(ceil(T_WP_PS/period), ceil(T_DW_PS/period)) cycles. During that time mem_cs_no is 0 and address and data are stable, and the addressed word takes the written bit.
- R6: After the write pulse, one recovery cycle has mem_we_no at 1, mem_cs_no at 0 and the address unchanged.
- R7: req_ready_o is 0 from acceptance until the sequence completes. It is high again in cycle ACC+1 after a read is accepted and in cycle PULSE+3 after a write is accepted.
- R8: If ret_req_i is high while the controller is idle, ret_ack_o rises on the next cycle with mem_cs_no and mem_we_no at 1. If ret_req_i rises during an access, the access finishes first, and retention wins over a request pending in the same cycle.
- R9: While retention is acknowledged or recovering, req_ready_o is 0 and a held request is stalled. It is accepted once recovery ends.
- R10: After ret_req_i falls, ret_ack_o is 0 from the next cycle, and req_ready_o stays 0 for REC = ceil(T_RC_PS/period) cycles after that.
- R11: Data written before a retention period reads back unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 14 | Word address |
| req_wdata_i | input | 1 | Write bit |
| rd_valid_o | output | 1 | One-cycle read-return pulse |
| rd_data_o | output | 1 | Returned read bit |
| ret_req_i | input | 1 | Request to enter supply retention |
| ret_ack_o | output | 1 | Memory parked, supply may be lowered |
| mem_addr_o | output | 14 | Memory address lines |
| mem_din_o | output | 1 | Memory data input pin |
| mem_dout_i | input | 1 | Memory data output pin |
| mem_cs_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write enable, active low |

## Verification
The bench builds the controller with a 4000 ps period, a 15000 ps access time and recovery time, a 13000 ps write pulse and an 18000 ps data-setup value. This gives ACC = 4, REC = 4 and a pulse of 5 cycles, so the pulse length comes from the data-setup count and not the pulse-width count, and that selection branch is exercised. The bench's memory model returns the inverted bit until the access window has elapsed, so sampling even one cycle early is visible on rd_data_o.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WSETUP, ST_WPULSE, ST_WREC
  } acc_state_e;

  typedef enum logic [1:0] {
    RS_RUN, RS_HOLD, RS_RECOVER
  } ret_state_e;

  function automatic int unsigned cyc_ceil(int unsigned ps, int unsigned period);
    int unsigned c;
    c = (ps + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  // len_i counts cycles; done marks the last one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ret_ctrl.sv
module ret_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned REC_CYC = 4,
  parameter int unsigned W       = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ret_req_i,
  input  logic acc_idle_i,
  output logic ret_ack_o,
  output logic ret_block_o
);
  ret_state_e st_q, st_d;
  logic       rec_load, rec_done;

  always_comb begin
    st_d     = st_q;
    rec_load = 1'b0;
    unique case (st_q)
      RS_RUN:     if (ret_req_i && acc_idle_i) st_d = RS_HOLD;
      RS_HOLD:    if (!ret_req_i) begin
                    st_d     = RS_RECOVER;
                    rec_load = 1'b1;
                  end
      RS_RECOVER: if (rec_done) st_d = RS_RUN;
      default:    st_d = RS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RS_RUN;
    else         st_q <= st_d;
  end

  phase_timer #(.W(W)) u_rec_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rec_load),
    .len_i  (W'(REC_CYC)),
    .done_o (rec_done)
  );

  assign ret_ack_o   = (st_q == RS_HOLD);
  assign ret_block_o = (st_q != RS_RUN);

  assert_enter_from_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ret_ack_o) |-> $past(acc_idle_i));

  assert_exit_to_recover_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_ack_o && !ret_req_i) |=> (!ret_ack_o && ret_block_o));
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 14,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned T_AA_PS       = 15000,
  parameter int unsigned T_WP_PS       = 13000,
  parameter int unsigned T_DW_PS       = 10000,
  parameter int unsigned T_RC_PS       = 15000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wdata_i,
  output logic              rd_valid_o,
  output logic              rd_data_o,
  input  logic              ret_req_i,
  output logic              ret_ack_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_din_o,
  input  logic              mem_dout_i,
  output logic              mem_cs_no,
  output logic              mem_we_no
);
  localparam int unsigned ACC_CYC   = cyc_ceil(T_AA_PS, CLK_PERIOD_PS);
  localparam int unsigned WP_CYC    = cyc_ceil(T_WP_PS, CLK_PERIOD_PS);
  localparam int unsigned DS_CYC    = cyc_ceil(T_DW_PS, CLK_PERIOD_PS);
  localparam int unsigned REC_CYC   = cyc_ceil(T_RC_PS, CLK_PERIOD_PS);
  localparam int unsigned PULSE_CYC = max2(WP_CYC, DS_CYC);
  localparam int unsigned CNT_W     = $clog2(max2(max2(ACC_CYC, PULSE_CYC), REC_CYC) + 1) + 1;

  acc_state_e        st_q, st_d;
  logic              accept, ret_block, tmr_load, tmr_done, capture;
  logic [CNT_W-1:0]  tmr_len;
  logic [ADDR_W-1:0] addr_q;
  logic              din_q, cs_n_q, we_n_q, rd_valid_q, rd_data_q;

  // retention has priority over a request pending in the same cycle
  assign req_ready_o = (st_q == ST_IDLE) && !ret_block && !ret_req_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_len  = CNT_W'(ACC_CYC);
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (req_write_i) st_d = ST_WSETUP;
        else begin
          st_d     = ST_READ;
          tmr_load = 1'b1;
        end
      end
      ST_READ: if (tmr_done) begin
        capture = 1'b1;
        st_d    = ST_IDLE;
      end
      ST_WSETUP: begin
        st_d     = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(PULSE_CYC);
      end
      ST_WPULSE: if (tmr_done) st_d = ST_WREC;
      ST_WREC:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  phase_timer #(.W(CNT_W)) u_phase_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  ret_ctrl #(.REC_CYC(REC_CYC), .W(CNT_W)) u_ret_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ret_req_i   (ret_req_i),
    .acc_idle_i  (st_q == ST_IDLE),
    .ret_ack_o   (ret_ack_o),
    .ret_block_o (ret_block)
  );

  // strobes come from flops, decoded from the next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      din_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      we_n_q     <= 1'b1;
      rd_valid_q <= 1'b0;
      rd_data_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      cs_n_q     <= (st_d == ST_IDLE);
      we_n_q     <= (st_d != ST_WPULSE);
      rd_valid_q <= capture;
      if (accept) begin
        addr_q <= req_addr_i;
        din_q  <= req_wdata_i;
      end
      if (capture) rd_data_q <= mem_dout_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_din_o  = din_q;
  assign mem_cs_no  = cs_n_q;
  assign mem_we_no  = we_n_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  assert_idle_standby_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_no && mem_we_no));

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));

  assert_rd_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  assert_we_inside_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs_no && $stable(mem_addr_o) && $stable(mem_din_o)));

  assert_we_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (!mem_cs_no && $stable(mem_addr_o)));

  assert_busy_not_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_no |-> !req_ready_o);

  assert_ret_parked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_ack_o |-> (mem_cs_no && mem_we_no));

  assert_ret_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_ack_o |-> !req_ready_o);
endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
  localparam int unsigned PER_PS = 4000;
  localparam int unsigned AA_PS  = 15000;
  localparam int unsigned WP_PS  = 13000;
  localparam int unsigned DW_PS  = 18000;
  localparam int unsigned RC_PS  = 15000;

  function automatic int bceil(int unsigned ps);
    return (ps + PER_PS - 1) / PER_PS;
  endfunction

  localparam int ACC   = (AA_PS + PER_PS - 1) / PER_PS;
  localparam int REC   = (RC_PS + PER_PS - 1) / PER_PS;
  localparam int WPC   = (WP_PS + PER_PS - 1) / PER_PS;
  localparam int DSC   = (DW_PS + PER_PS - 1) / PER_PS;
  localparam int PULSE = (WPC > DSC) ? WPC : DSC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0, ret_req = 1'b0;
  logic [13:0] req_addr = '0;
  logic        req_ready, rd_valid, rd_data, ret_ack, mem_din, mem_dout, cs_n, we_n;
  logic [13:0] mem_addr;

  logic [16383:0] ram_q = '0;
  logic [16383:0] shadow = '0;
  int unsigned    rd_age = 0;
  int             checks = 0, fails = 0;

  always #2ns clk = ~clk;

  sram_seq_ctrl #(
    .ADDR_W(14), .CLK_PERIOD_PS(PER_PS), .T_AA_PS(AA_PS),
    .T_WP_PS(WP_PS), .T_DW_PS(DW_PS), .T_RC_PS(RC_PS)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .ret_req_i(ret_req), .ret_ack_o(ret_ack),
    .mem_addr_o(mem_addr), .mem_din_o(mem_din), .mem_dout_i(mem_dout),
    .mem_cs_no(cs_n), .mem_we_no(we_n)
  );

  // memory model: output is wrong until the access window has elapsed
  always @(posedge clk) begin
    if (!cs_n && !we_n) ram_q[mem_addr] <= mem_din;
    if (!cs_n && we_n) rd_age <= rd_age + 1;
    else               rd_age <= 0;
  end
  assign mem_dout = (!cs_n && we_n) ?
                    ((rd_age >= ACC - 1) ? ram_q[mem_addr] : ~ram_q[mem_addr]) : 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic do_write(input logic [13:0] a, input logic d);
    int n;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1;
    chk(!cs_n && we_n && mem_addr == a && mem_din == d, "R4", "setup phase", {cs_n, we_n}, 2'b01);
    while (!req_ready && n < 64) begin
      if (n >= 2 && n <= PULSE + 1)
        chk(!we_n && !cs_n && mem_addr == a && mem_din == d, "R5", "pulse phase", we_n, 0);
      if (n == PULSE + 2)
        chk(we_n && !cs_n && mem_addr == a, "R6", "recovery phase", {cs_n, we_n}, 2'b01);
      @(negedge clk);
      n++;
    end
    chk(n == PULSE + 3, "R7", "write ready return cycle", n, PULSE + 3);
    chk(cs_n && we_n, "R1", "standby after write", {cs_n, we_n}, 2'b11);
    chk(ram_q[a] == d, "R5", "word written", ram_q[a], d);
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [13:0] a, output logic got, output int stall);
    int n;
    req_valid = 1; req_write = 0; req_addr = a;
    stall = 0;
    while (!req_ready && stall < 200) begin
      @(negedge clk);
      stall++;
    end
    @(negedge clk);
    req_valid = 0;
    n = 1;
    while (!rd_valid && n < 64) begin
      if (n <= ACC)
        chk(!cs_n && we_n && mem_addr == a, "R2", "read strobes", {cs_n, we_n}, 2'b01);
      chk(!req_ready, "R7", "busy during read", req_ready, 0);
      @(negedge clk);
      n++;
    end
    chk(n == ACC + 1, "R3", "read return cycle", n, ACC + 1);
    chk(rd_data == shadow[a], "R3", "read data", rd_data, shadow[a]);
    chk(req_ready && cs_n, "R7", "ready with return", req_ready, 1);
    got = rd_data;
    @(negedge clk);
    chk(!rd_valid, "R3", "valid is one cycle", rd_valid, 0);
  endtask

  initial begin
    logic got;
    int   st, n;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(cs_n && we_n && !rd_valid && !ret_ack, "R1", "reset strobes", {cs_n, we_n, rd_valid}, 3'b110);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && cs_n && we_n, "R1", "idle after reset", req_ready, 1);
    chk(PULSE == bceil(DW_PS), "R5", "pulse from data setup", PULSE, bceil(DW_PS));

    // directed corners: address extremes, both polarities
    do_write(14'h0000, 1'b1);
    do_write(14'h3fff, 1'b1);
    do_read(14'h0000, got, st);
    do_read(14'h3fff, got, st);
    do_write(14'h3fff, 1'b0);
    do_read(14'h3fff, got, st);
    do_read(14'h1234, got, st);

    // retention while idle, with a request held against it
    ret_req = 1;
    @(negedge clk);
    chk(ret_ack && cs_n && we_n && !req_ready, "R8", "retention entry", ret_ack, 1);
    req_valid = 1; req_write = 0; req_addr = 14'h3fff;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!req_ready && cs_n && ret_ack, "R9", "stalled in retention", req_ready, 0);
    end
    ret_req = 0;
    do_read(14'h3fff, got, st);
    chk(st == REC + 1, "R10", "recovery stall length", st, REC + 1);
    chk(got == 1'b0, "R11", "retained data", got, 0);
    chk(!ret_ack, "R10", "ack dropped", ret_ack, 0);

    // retention requested in the middle of a write
    req_valid = 1; req_write = 1; req_addr = 14'h0a5a; req_wdata = 1;
    @(negedge clk);
    req_valid = 0;
    ret_req = 1;
    n = 1;
    while (!ret_ack && n < 64) begin
      chk(!req_ready, "R8", "no accept while retention pending", req_ready, 0);
      @(negedge clk);
      n++;
    end
    chk(n == PULSE + 4, "R8", "ack after access completes", n, PULSE + 4);
    chk(ram_q[14'h0a5a] == 1'b1, "R8", "write finished before retention", ram_q[14'h0a5a], 1);
    shadow[14'h0a5a] = 1'b1;
    repeat (5) @(negedge clk);
    ret_req = 0;
    @(negedge clk);
    n = 1;
    chk(!ret_ack && !req_ready, "R10", "recovery starts", ret_ack, 0);
    while (!req_ready && n < 64) begin
      @(negedge clk);
      n++;
    end
    chk(n == REC + 1, "R10", "recovery window", n, REC + 1);
    do_read(14'h0a5a, got, st);
    chk(got == 1'b1, "R11", "data kept over retention", got, 1);

    // constrained random traffic
    for (int i = 0; i < 250; i++) begin
      logic [13:0] a;
      a = ($urandom_range(0, 3) == 0) ? 14'($urandom) : 14'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 1) do_write(a, 1'($urandom));
      else                           do_read(a, got, st);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired act=%0d exp=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule